// File: doc/BRIEF.md
# Pipelined Cascadable Parity Checker

This block checks parity over a ten-bit data word against a separate parity bit that reaches it one clock after the word it covers. The word is held in a pipeline register for one cycle so that it meets its parity bit. The combined sum is then loaded into an error register, which drives an open-drain style error output one clock after the parity bit. The error output only ever pulls low. A shared active-low output enable releases it.

A bidirectional parity pin, modelled as an input, an output and a drive enable, sets how the sum is judged. When the local cascade enable is high, the pin is an input. In single-device use it picks the polarity: low for even, high for odd. In the second device of a chained pair it carries the partial sum of the first device, and that sum is folded into the local check. When the cascade enable is low, the block drives its own partial sum out on the pin for a partner device. In that case it checks its own sum as even parity.

Top module: `casc_parity_chk`

## Requirements
- R1: While reset is asserted and right after it, the error output is released (`err_pd_o` = 0) and the data pipeline register holds zero.
- R2: The data word sampled at one rising edge is the word combined with the parity bit sampled at the next rising edge.
- R3: The error output changes only at the rising edge that follows the cycle in which the parity bit and the load enable were presented.
- R4: With `casc_oe_n` = 1 and `ppin_i` = 0, an error is flagged when the delayed word plus the parity bit holds an odd number of ones. With `ppin_i` = 1, an error is flagged when that count is even.
- R5: When `err_ld_n` = 1 at a rising edge, the error register keeps its previous value.
- R6: When `oe_n` = 1, `err_pd_o` is 0 whatever is stored. The stored value reappears when `oe_n` returns low.
- R7: With `casc_oe_n` = 0, `ppin_oe_o` = 1 and `ppin_o` equals the XOR of the delayed word and the current parity bit. The local check then treats the pin value as 0 and ignores `ppin_i`.
- R8: With `casc_oe_n` = 1, `ppin_oe_o` = 0 and the value on `ppin_i` is XORed into the check, so that a partner's partial sum is combined with the local one.
- R9: `err_pd_o` = 1 (pull low) exactly when the stored error is 1 and `oe_n` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| dat_i | input | 10 | Data word to be checked |
| err_ld_n | input | 1 | Active-low load enable of the error register |
| par_bit_i | input | 1 | Parity bit, one cycle behind its word |
| oe_n | input | 1 | Active-low output enable of the error output |
| casc_oe_n | input | 1 | Active-low enable for driving the partial sum on the parity pin |
| ppin_i | input | 1 | Parity pin, input side (polarity or partner partial sum) |
| ppin_o | output | 1 | Parity pin, output side (local partial sum) |
| ppin_oe_o | output | 1 | Parity pin drive enable |
| err_pd_o | output | 1 | Open-drain error: 1 pulls the line low |

## Verification
Every one of the 1024 data words is paired with both parity-bit values and both pin polarities in single-device use. Each new word arrives together with the parity bit of the previous word, so a pipeline that is skewed by one cycle gives wrong flags. Pin-drive cycles check the driven partial sum against the word count and show that `ppin_i` is ignored while driving. Receive cycles show a partner sum being folded in. Directed sequences hold the error register with the load enable, release and restore the output with `oe_n`, and confirm that the flag does not move before the expected edge.

// File: rtl/pcc_pkg.sv
package pcc_pkg;

  typedef enum logic {
    ROLE_LISTEN = 1'b0,
    ROLE_DRIVE  = 1'b1
  } pin_role_e;

  function automatic pin_role_e role_of(input logic casc_oe_n);
    return casc_oe_n ? ROLE_LISTEN : ROLE_DRIVE;
  endfunction

  function automatic logic ref_bit(input pin_role_e role, input logic pin_in);
    return (role == ROLE_LISTEN) ? pin_in : 1'b0;
  endfunction

  function automatic logic merge_sum(input logic partial, input logic refv);
    return partial ^ refv;
  endfunction

endpackage

// File: rtl/pcc_data_stage.sv
module pcc_data_stage #(
  parameter int DATA_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] dat_i,
  output logic [DATA_W-1:0] dat_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dat_q <= '0;
    else        dat_q <= dat_i;
  end

  AST_DATA_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> dat_q == $past(dat_i)); // R2

endmodule

// File: rtl/pcc_sum.sv
module pcc_sum #(
  parameter int DATA_W = 10
) (
  input  logic [DATA_W-1:0] dat_q,
  input  logic              par_bit_i,
  input  logic              casc_oe_n,
  input  logic              pin_in,
  output logic              partial_o,
  output logic              drive_o,
  output logic              chk_o
);
  import pcc_pkg::*;

  pin_role_e role;
  logic      refv;

  assign role      = role_of(casc_oe_n);
  assign partial_o = (^dat_q) ^ par_bit_i;
  assign drive_o   = (role == ROLE_DRIVE);
  assign refv      = ref_bit(role, pin_in);
  assign chk_o     = merge_sum(partial_o, refv);

endmodule

// File: rtl/pcc_err_reg.sv
module pcc_err_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic ld_n,
  input  logic chk_i,
  output logic err_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     err_q <= 1'b0;
    else if (!ld_n) err_q <= chk_i;
  end

  AST_ERR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ld_n |=> $stable(err_q)); // R5

  AST_ERR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_n |=> err_q == $past(chk_i)); // R3

endmodule

// File: rtl/casc_parity_chk.sv
module casc_parity_chk #(
  parameter int DATA_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] dat_i,
  input  logic              err_ld_n,
  input  logic              par_bit_i,
  input  logic              oe_n,
  input  logic              casc_oe_n,
  input  logic              ppin_i,
  output logic              ppin_o,
  output logic              ppin_oe_o,
  output logic              err_pd_o
);

  logic [DATA_W-1:0] dat_q;
  logic              partial;
  logic              drive;
  logic              chk;
  logic              err_q;

  pcc_data_stage #(.DATA_W(DATA_W)) u_data (
    .clk   (clk),
    .rst_n (rst_n),
    .dat_i (dat_i),
    .dat_q (dat_q)
  );

  pcc_sum #(.DATA_W(DATA_W)) u_sum (
    .dat_q     (dat_q),
    .par_bit_i (par_bit_i),
    .casc_oe_n (casc_oe_n),
    .pin_in    (ppin_i),
    .partial_o (partial),
    .drive_o   (drive),
    .chk_o     (chk)
  );

  pcc_err_reg u_err (
    .clk   (clk),
    .rst_n (rst_n),
    .ld_n  (err_ld_n),
    .chk_i (chk),
    .err_q (err_q)
  );

  assign ppin_o    = partial;
  assign ppin_oe_o = drive;
  assign err_pd_o  = err_q & ~oe_n;

  AST_DRIVE_SELF_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!err_ld_n && !casc_oe_n) |=> err_q == $past(ppin_o)); // R7

  AST_LISTEN_MERGE: assert property (@(posedge clk) disable iff (!rst_n)
    (!err_ld_n && casc_oe_n) |=> err_q == ($past(ppin_o) ^ $past(ppin_i))); // R8

  AST_PULL_NEEDS_OE: assert property (@(posedge clk) disable iff (!rst_n)
    err_pd_o |-> (!oe_n && err_q)); // R9

endmodule

// File: tb/casc_parity_chk_tb.sv
module casc_parity_chk_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [DW-1:0] dat_i = '0;
  logic          err_ld_n = 1'b1;
  logic          par_bit_i = 1'b0;
  logic          oe_n = 1'b0;
  logic          casc_oe_n = 1'b1;
  logic          ppin_i = 1'b0;
  logic          ppin_o, ppin_oe_o, err_pd_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  logic [DW-1:0] m_dat = '0;
  logic          m_err = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  casc_parity_chk #(.DATA_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .dat_i(dat_i), .err_ld_n(err_ld_n),
    .par_bit_i(par_bit_i), .oe_n(oe_n), .casc_oe_n(casc_oe_n),
    .ppin_i(ppin_i), .ppin_o(ppin_o), .ppin_oe_o(ppin_oe_o),
    .err_pd_o(err_pd_o)
  );

  task automatic chk(input logic act, input logic exp, input string req);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%b exp=%b at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic odd_of(input logic [DW-1:0] d, input logic p);
    return logic'(($countones(d) + int'(p)) % 2);
  endfunction

  // one cycle: inputs set after a falling edge, checks before and after the rising edge
  task automatic step(input logic [DW-1:0] d, input logic p, input logic ld,
                      input logic pin, input logic casc, input logic oe);
    logic refv;
    dat_i = d; par_bit_i = p; err_ld_n = ld; ppin_i = pin;
    casc_oe_n = casc; oe_n = oe;
    #1;
    chk(ppin_oe_o, ~casc, "R7/R8 pin drive enable");
    if (!casc) chk(ppin_o, odd_of(m_dat, p), "R7 driven partial sum");
    chk(err_pd_o, m_err & ~oe, "R3 no change before edge");
    refv = casc ? pin : 1'b0;
    @(posedge clk);
    if (!ld) m_err = odd_of(m_dat, p) ^ refv;
    m_dat = d;
    @(negedge clk);
    chk(err_pd_o, m_err & ~oe, "R2/R4/R9 error after edge");
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_tests++; n_fail++;
    $display("FAIL watchdog act=hung exp=finished");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(err_pd_o, 1'b0, "R1 released in reset");
    chk(ppin_oe_o, 1'b0, "R8 listening in reset");
    rst_n = 1'b1;
    @(negedge clk);
    chk(err_pd_o, 1'b0, "R1 released after reset");
    // R1: pipeline cleared -> zero word, parity 0, even => no error
    step('0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    chk(err_pd_o, 1'b0, "R1 cleared pipeline gives no error");

    // R4/R2 sweep: every word, both parity bits, both polarities
    for (int pol = 0; pol < 2; pol++)
      for (int pb = 0; pb < 2; pb++)
        for (int w = 0; w < 1024; w++)
          step(DW'(w), logic'(pb), 1'b0, logic'(pol), 1'b1, 1'b0);

    // R7: driving mode, ppin_i toggled but ignored
    for (int w = 0; w < 256; w++)
      step(DW'(w * 37), logic'(w[1]), 1'b0, logic'(w[0]), 1'b0, 1'b0);

    // R8: partner partial sum folded in
    for (int w = 0; w < 256; w++)
      step(DW'(w * 11 + 5), logic'(w[2]), 1'b0, logic'(w[0] ^ w[3]), 1'b1, 1'b0);

    // R5: force an error then hold it with load disabled
    step(10'h001, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    step(10'h000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0); // loads odd count => error
    chk(err_pd_o, 1'b1, "R4 odd count under even flagged");
    step(10'h000, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0);
    step(10'h000, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0);
    chk(err_pd_o, 1'b1, "R5 held while load disabled");

    // R6: output enable releases, then restores stored error
    step(10'h3ff, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1);
    chk(err_pd_o, 1'b0, "R6 released by oe_n");
    step(10'h3ff, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0);
    chk(err_pd_o, 1'b1, "R6 stored error reappears");

    // R3: clear, then check that the flag only moves at the edge
    step(10'h000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    chk(err_pd_o, 1'b0, "R3 cleared on load");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule